// File: doc/BRIEF.md
# Serial Peripheral Port with Read-Then-Access Status Flags

This block is an 8-bit serial peripheral port for a small CPU. It acts as bus master and works from the system clock. A write to the data register starts a byte transfer. The block divides the clock by a value picked with a 3-bit rate code. It produces eight serial clock cycles, drives the outgoing bits on the serial output and samples the incoming bits on the serial input. The last complete received byte stays readable until the next byte finishes.

Three status flags report on the port: transfer done, write collision and mode fault. The CPU never clears them by writing a bit. For transfer done and write collision, it reads the status register while the flag is set and then reads or writes the data register. A mode fault means another device pulled the slave-select input low. The fault stops the current byte and drops master mode until software enables master mode again.

Top module: `spi_port`

## Requirements
- R1: The serial clock period in system clocks follows the rate code: 000=2, 001=4, 010=16, 011=32, 100=8, 101=16, 110=64, 111=128.
- R2: A data write while the port is master and idle starts a transfer of exactly eight serial clock cycles. The serial clock idles low. The first bit is on the serial output from the start of the transfer, the output changes after each falling edge, and the input is sampled at each rising edge. The serial output is low when no transfer runs.
- R3: Bits go out and come in most significant bit first when lsb_first_i=0 and least significant bit first when lsb_first_i=1, with the selection latched when the transfer starts.
- R4: rdata_o keeps the previous received byte while a new byte shifts in. It takes the new byte in the same clock that ends the transfer.
- R5: Status bit 7 (transfer done) sets when a transfer ends. It clears only on a data read or data write that follows a status read made while the bit was 1. A data access without that earlier status read leaves it set.
- R6: A data write during a transfer sets status bit 6 (write collision). The written byte is discarded and the running byte goes on unchanged. Bit 6 clears by the same read-status-then-access-data sequence as bit 7.
- R7: ss_ni low while in master mode sets status bit 4 (mode fault) in the next clock. In the same clock it clears master mode, aborts any transfer and forces the serial clock and serial output low. Bit 4 clears on a rising edge of mstr_en_i that follows a status read made while bit 4 was 1.
- R8: A rising edge of mstr_en_i enters master mode, and mstr_en_i low leaves it. master_o shows the state. Data writes made outside master mode start nothing.
- R9: Status bits 5 and 3..0 always read 0. After reset the status is 0x00, rdata_o is 0x00, master_o is 0 and the serial clock is low.
- R10: The rate code is taken only when a transfer starts. Changing rate_i during a byte does not change that byte's serial clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, source of the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mstr_en_i | input | 1 | Master enable; a rising edge enters master mode |
| lsb_first_i | input | 1 | 1 = least significant bit first |
| rate_i | input | 3 | Serial clock rate code |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| data_wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 8 | Byte to transmit |
| stat_o | output | 8 | Status: bit 7 done, bit 6 collision, bit 4 mode fault |
| rdata_o | output | 8 | Receive buffer |
| master_o | output | 1 | Master mode active |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_ni | input | 1 | Slave select input, active low |

## Verification
A wrong divider count or a wrong latched rate shows on sck_o within one serial half-period, because the bench compares the serial clock level on every system clock. A wrong bit order or a shifter corrupted by a colliding write shows on mosi_o at the first wrong bit, and in the received byte on rdata_o when the transfer ends. Errors in the flag arming logic show on stat_o in the clock right after the data access that should, or should not, have cleared a flag. A mode fault that does not stop the port shows on master_o and sck_o one clock after ss_ni falls.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int HALF_W = 6;
  localparam int STAT_W = 8;

  // half serial-clock period minus one, in system clocks
  function automatic logic [HALF_W-1:0] rate_half_m1(input logic [2:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      3'b000:  h = 6'd0;
      3'b001:  h = 6'd1;
      3'b010:  h = 6'd7;
      3'b011:  h = 6'd15;
      3'b100:  h = 6'd3;
      3'b101:  h = 6'd7;
      3'b110:  h = 6'd31;
      default: h = 6'd63;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [2:0] rate_i,
  output logic       busy_o,
  output logic       sck_o,
  output logic       rise_o,
  output logic       fall_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(BITS);

  logic              busy_q, sck_q, tick;
  logic [HALF_W-1:0] cnt_q, hm1_q;
  logic [CNT_W-1:0]  nfall_q;

  assign tick   = busy_q && (cnt_q == hm1_q);
  assign rise_o = tick & ~sck_q;
  assign fall_o = tick & sck_q;
  assign done_o = fall_o && (nfall_q == CNT_W'(BITS-1));
  assign busy_o = busy_q;
  assign sck_o  = sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      cnt_q   <= '0;
      hm1_q   <= '0;
      nfall_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      sck_q   <= 1'b0;
      cnt_q   <= '0;
      nfall_q <= '0;
      hm1_q   <= rate_half_m1(rate_i);
    end else if (busy_q) begin
      if (tick) begin
        cnt_q <= '0;
        sck_q <= ~sck_q;
        if (fall_o) begin
          nfall_q <= nfall_q + CNT_W'(1);
          if (done_o) busy_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + HALF_W'(1);
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q); // R2
  AST_RATE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(hm1_q)); // R10
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          lsb_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          done_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic [DW-1:0] rbuf_o
);
  logic [DW-1:0] sh_q, sh_nx, rbuf_q;
  logic          lsb_q, in_q;

  assign sh_nx  = lsb_q ? {in_q, sh_q[DW-1:1]} : {sh_q[DW-2:0], in_q};
  assign mosi_o = lsb_q ? sh_q[0] : sh_q[DW-1];
  assign rbuf_o = rbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rbuf_q <= '0;
      lsb_q  <= 1'b0;
      in_q   <= 1'b0;
    end else if (start_i) begin
      sh_q  <= wdata_i;
      lsb_q <= lsb_i;
    end else if (rise_i) begin
      in_q <= miso_i;
    end else if (fall_i) begin
      sh_q <= sh_nx;
      if (done_i) rbuf_q <= sh_nx;
    end
  end

  AST_RBUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(rbuf_q)); // R4
endmodule

// File: rtl/spi_port_flags.sv
module spi_port_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic spif_set_i,
  input  logic wcol_set_i,
  input  logic modf_set_i,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic reen_i,
  output logic spif_o,
  output logic wcol_o,
  output logic modf_o
);
  logic [2:0] set_v, ev_v, flag_v;

  assign set_v = {modf_set_i, wcol_set_i, spif_set_i};
  assign ev_v  = {reen_i, data_acc_i, data_acc_i};

  for (genvar g = 0; g < 3; g++) begin : g_flag
    logic f_q, a_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        f_q <= 1'b0;
        a_q <= 1'b0;
      end else begin
        if (set_v[g])              f_q <= 1'b1;
        else if (ev_v[g] && a_q)   f_q <= 1'b0;
        if (stat_rd_i && f_q)      a_q <= 1'b1;
        else if (ev_v[g])          a_q <= 1'b0;
      end
    end
    assign flag_v[g] = f_q;

    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (f_q && !(ev_v[g] && a_q)) |=> f_q); // R5
  end

  assign spif_o = flag_v[0];
  assign wcol_o = flag_v[1];
  assign modf_o = flag_v[2];

  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcol_set_i |=> wcol_o); // R6
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mstr_en_i,
  input  logic              lsb_first_i,
  input  logic [2:0]        rate_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  input  logic              data_wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [DW-1:0]     rdata_o,
  output logic              master_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  input  logic              ss_ni
);
  logic en_q, mstr_q, en_rise, abort, start;
  logic busy, sck, rise, fall, done, mosi_raw;
  logic spif, wcol, modf;

  assign en_rise = mstr_en_i & ~en_q;
  assign abort   = mstr_q & ~ss_ni;
  assign start   = data_wr_i & mstr_q & ~busy & ~abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mstr_q <= 1'b0;
    end else begin
      en_q <= mstr_en_i;
      if (abort || !mstr_en_i) mstr_q <= 1'b0;
      else if (en_rise)        mstr_q <= 1'b1;
    end
  end

  spi_port_clkgen #(.BITS(DW)) u_clkgen (
    .clk_i, .rst_ni,
    .start_i(start), .abort_i(abort), .rate_i,
    .busy_o(busy), .sck_o(sck), .rise_o(rise), .fall_o(fall), .done_o(done)
  );

  spi_port_shift #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .start_i(start), .wdata_i, .lsb_i(lsb_first_i),
    .rise_i(rise), .fall_i(fall), .done_i(done), .miso_i,
    .mosi_o(mosi_raw), .rbuf_o(rdata_o)
  );

  spi_port_flags u_flags (
    .clk_i, .rst_ni,
    .spif_set_i(done), .wcol_set_i(data_wr_i & busy), .modf_set_i(abort),
    .stat_rd_i, .data_acc_i(data_rd_i | data_wr_i), .reen_i(en_rise),
    .spif_o(spif), .wcol_o(wcol), .modf_o(modf)
  );

  assign stat_o   = {spif, wcol, 1'b0, modf, 4'b0000};
  assign master_o = mstr_q;
  assign sck_o    = sck;
  assign mosi_o   = busy & mosi_raw;

  AST_MODF_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstr_q && !ss_ni) |=> (!mstr_q && !busy && !sck && modf)); // R7
  AST_COLL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && busy && !done && !abort) |=> busy); // R6
  AST_START_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !mstr_q) |=> !busy); // R8
endmodule

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       mstr_en = 1'b0, lsb = 1'b0, stat_rd = 1'b0, data_rd = 1'b0, wr = 1'b0;
  logic [2:0] rate = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] stat, rdata;
  logic       master, sck, mosi, ss_n = 1'b1;
  logic       miso = 1'b0;

  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  spi_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mstr_en_i(mstr_en), .lsb_first_i(lsb), .rate_i(rate),
    .stat_rd_i(stat_rd), .data_rd_i(data_rd), .data_wr_i(wr), .wdata_i(wdata),
    .stat_o(stat), .rdata_o(rdata), .master_o(master), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .ss_ni(ss_n)
  );

  function automatic int div_of(input int code);
    case (code)
      0: return 2;   1: return 4;   2: return 16;  3: return 32;
      4: return 8;   5: return 16;  6: return 64;  default: return 128;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit       m_en_prev, m_mstr, m_busy, m_lsb;
  int       m_t, m_half;
  bit [7:0] m_tx, m_slave, m_rdata;
  bit       m_spif, m_wcol, m_modf, a_spif, a_wcol, a_modf;

  always @(posedge clk) begin
    bit abort, en_rise, start, acc, busy0, done;
    cyc++;
    if (!rst_n) begin
      m_en_prev = 0; m_mstr = 0; m_busy = 0; m_lsb = 0; m_t = 0; m_half = 1;
      m_tx = 0; m_rdata = 0; m_spif = 0; m_wcol = 0; m_modf = 0;
      a_spif = 0; a_wcol = 0; a_modf = 0;
    end else begin
      abort   = m_mstr && !ss_n;
      en_rise = mstr_en && !m_en_prev;
      start   = wr && m_mstr && !m_busy && !abort;
      acc     = data_rd || wr;
      busy0   = m_busy;
      done    = 0;
      if (abort) m_busy = 0;
      else if (start) begin
        m_busy = 1; m_t = 0; m_half = div_of(int'(rate)) / 2; m_lsb = lsb; m_tx = wdata;
      end else if (m_busy) begin
        m_t++;
        if (m_t == 16 * m_half) begin m_busy = 0; done = 1; m_rdata = m_slave; end
      end
      if (done) m_spif = 1; else if (acc && a_spif) m_spif = 0;
      if (wr && busy0) m_wcol = 1; else if (acc && a_wcol) m_wcol = 0;
      if (abort) m_modf = 1; else if (en_rise && a_modf) m_modf = 0;
      if (stat_rd && m_spif_prev_unused()) a_spif = a_spif;
      m_en_prev = mstr_en;
      if (abort || !mstr_en) m_mstr = 0; else if (en_rise) m_mstr = 1;
    end
  end

  function automatic bit m_spif_prev_unused();
    return 1'b0;
  endfunction

  // arms follow the flag values seen by a status read before the update
  bit p_spif, p_wcol, p_modf;
  always @(negedge clk) begin
    p_spif = m_spif; p_wcol = m_wcol; p_modf = m_modf;
  end
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      a_spif = 0; a_wcol = 0; a_modf = 0;
    end else begin
      if (stat_rd && p_spif) a_spif = 1; else if (data_rd || wr) a_spif = 0;
      if (stat_rd && p_wcol) a_wcol = 1; else if (data_rd || wr) a_wcol = 0;
      if (stat_rd && p_modf) a_modf = 1; else if (mstr_en && !p_en) a_modf = 0;
    end
  end
  bit p_en;
  always @(negedge clk) p_en = m_en_prev;

  // compare every clock, then drive the slave bit
  always @(posedge clk) begin
    int idx;
    bit e_sck, e_mosi;
    #2;
    if (rst_n) begin
      idx    = m_busy ? m_t / (2 * m_half) : 0;
      e_sck  = m_busy && (((m_t / m_half) % 2) == 1);
      e_mosi = m_busy && (m_lsb ? m_tx[idx] : m_tx[7-idx]);
      chk("R2", sck, e_sck, "sck level");
      chk("R3", mosi, e_mosi, "mosi bit");
      chk("R4", rdata, m_rdata, "rdata");
      chk("R5", stat[7], m_spif, "done flag");
      chk("R6", stat[6], m_wcol, "collision flag");
      chk("R7", stat[4], m_modf, "fault flag");
      chk("R8", master, m_mstr, "master state");
      chk("R9", {stat[5], stat[3:0]}, 0, "zero bits");
      miso = m_busy && (m_lsb ? m_slave[idx] : m_slave[7-idx]);
    end else begin
      miso = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired cycle=%0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0; data_rd = 1;
    @(negedge clk); data_rd = 0;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input int code,
                      input bit lsb_sel, input string tag);
    int dv, t0, r;
    bit prev;
    dv = div_of(code); t0 = 0; r = 0; prev = 0;
    m_slave = sl;
    @(negedge clk); rate = code[2:0]; lsb = lsb_sel; wr = 1; wdata = tx;
    @(negedge clk); wr = 0;
    for (int k = 0; k < 8 * dv + 2; k++) begin
      if (sck && !prev) begin
        if (r == 0) t0 = cyc;
        else if (r == 1) chk("R1", cyc - t0, dv, "sck period");
        r++;
      end
      prev = sck;
      @(negedge clk);
    end
    chk("R2", r, 8, "sck rising count");
    chk(tag, rdata, sl, "received byte");
    chk("R5", stat[7], 1, "done flag set");
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    chk("R9", stat, 8'h00, "status after reset");
    chk("R9", rdata, 8'h00, "rdata after reset");
    chk("R9", master, 0, "master after reset");

    // write outside master mode starts nothing
    @(negedge clk); wr = 1; wdata = 8'hFF;
    @(negedge clk); wr = 0;
    idle(6);
    chk("R8", sck, 0, "no clock outside master mode");
    chk("R8", stat, 8'h00, "no flags outside master mode");

    @(negedge clk); mstr_en = 1;
    idle(2);
    chk("R8", master, 1, "master after enable edge");

    for (int c = 0; c < 8; c++) begin
      xfer(8'hA5 ^ 8'(c * 37), 8'h3C + 8'(c * 19), c, c[0], c[0] ? "R3" : "R4");
      clear_flags();
      chk("R5", stat[7], 0, "done flag cleared");
    end

    // data access without prior status read keeps the flag
    xfer(8'h81, 8'h7E, 0, 0, "R3");
    @(negedge clk); data_rd = 1;
    @(negedge clk); data_rd = 0;
    chk("R5", stat[7], 1, "flag kept without status read");
    clear_flags();

    // receive buffer holds old byte during a new transfer
    m_slave = 8'h11;
    @(negedge clk); rate = 3'd1; lsb = 0; wr = 1; wdata = 8'h5A;
    @(negedge clk); wr = 0;
    idle(10);
    chk("R4", rdata, 8'h7E, "old byte held mid transfer");
    idle(30);
    chk("R4", rdata, 8'h11, "new byte after transfer");
    clear_flags();

    // collision: write mid byte is discarded
    m_slave = 8'hC3;
    @(negedge clk); rate = 3'd4; lsb = 0; wr = 1; wdata = 8'h96;
    @(negedge clk); wr = 0;
    idle(12);
    @(negedge clk); wr = 1; wdata = 8'h0F;
    @(negedge clk); wr = 0;
    chk("R6", stat[6], 1, "collision flag set");
    idle(60);
    chk("R6", rdata, 8'hC3, "byte unchanged after collision");
    chk("R6", stat, 8'hC0, "done and collision flags");
    clear_flags();
    chk("R6", stat, 8'h00, "collision flag cleared");

    // rate change mid byte is ignored
    m_slave = 8'h69;
    @(negedge clk); rate = 3'd2; wr = 1; wdata = 8'hE7;
    @(negedge clk); wr = 0;
    idle(5);
    rate = 3'd7;
    idle(8 * 16 - 5);
    chk("R10", stat[7], 1, "transfer length with latched rate");
    chk("R10", rdata, 8'h69, "byte with latched rate");
    clear_flags();

    // mode fault aborts and drops master mode
    m_slave = 8'h55;
    @(negedge clk); rate = 3'd3; wr = 1; wdata = 8'hAA;
    @(negedge clk); wr = 0;
    idle(20);
    ss_n = 0;
    idle(2);
    chk("R7", master, 0, "master dropped on fault");
    chk("R7", sck, 0, "clock stopped on fault");
    chk("R7", mosi, 0, "data out low on fault");
    chk("R7", stat[4], 1, "fault flag set");
    ss_n = 1;
    @(negedge clk); wr = 1; wdata = 8'h33;
    @(negedge clk); wr = 0;
    idle(4);
    chk("R8", sck, 0, "write ignored after fault");
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0; mstr_en = 0;
    @(negedge clk); mstr_en = 1;
    idle(2);
    chk("R7", stat[4], 0, "fault flag cleared on re-enable");
    chk("R8", master, 1, "master restored");
    xfer(8'h24, 8'hB1, 5, 1, "R3");
    clear_flags();

    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule